// File: doc/BRIEF.md
# Key-Protected Control Register File

This block is a bank of 32-bit control registers on a simple word bus made up of a write enable, a read enable, a byte address, write data and read data. A key register at word 0 opens and closes write access to a protected window of the map. A write of the unlock constant to word 0 opens the window, and a write of any other value closes it. Several registers are reached through two neighbouring addresses. The lower address ORs ones into the stored word and the upper address clears bits.

Two of these paired registers hold hardware straps. Each strap has a protect word two words above its set address. Further registers are read-only: a revision word, two identity words and a random-data word. The random-data word is served by a 32-bit Galois LFSR that steps on every read of it.

Reset loads fixed defaults. The straps, the revision word and the initial key state come from input ports.

Word map, as word indices (byte address bits [11:2]):
- Key: index 0.
- Revision: index 1.
- Identity words: indices 2 and 3.
- Set/clear pairs p = 0..3: set at 4+4p, clear at 5+4p. Pairs 2 and 3 are the straps.
- Strap protect words: indices 14 and 18.
- Clock parameter: index 20.
- Clock extension: index 21.
- Random control: index 22.
- Random data: index 23.
- Scratch: indices 24..27.
- Open scratch: index PROT_LIMIT (default 48).

Top module: `keyed_ctrl_regs`

## Requirements
- R1: Reset state. The key flag equals `keyInit`. Pair 2 equals `strapAInit`, pair 3 equals `strapBInit`, and the revision word equals `revisionIn`. Pair 0 resets to 32'hF0C30ED8 and pair 1 to 32'h0FF07F8A. The identity words read 32'h5A5A0001 and 32'h0000C0DE. The clock parameter resets to 32'h100040A1 and the random control to 32'h0000000E. All other words reset to 0.
- R2: A write to index 0 stores 1 when the data equals KEY_VALUE (default 32'h1688A8A8) and stores 0 for any other data. A read of index 0 returns the flag in bit 0 with bits 31..1 at zero.
- R3: While the key flag is 0, writes to indices 1 through PROT_LIMIT-1 have no effect. The open scratch at index PROT_LIMIT accepts writes whatever the flag.
- R4: A write to the set address of a pair ORs the write data into its stored word.
- R5: A write to the clear address of a pair clears the stored bits where the data holds a 1. A read of either address of a pair returns the stored word.
- R6: A strap pair ignores writes to its set address while its protect word is nonzero. Writes to its clear address still take effect.
- R7: Writes to the revision word, the identity words and the random-data word are discarded.
- R8: A read of the clock extension (index 21) returns the stored value with bit 31 forced to 1.
- R9: Each read of index 23 returns the LFSR state and then advances it. The state starts at LFSR_SEED (default 32'h2468ACE1). The next state is (s >> 1) XOR (s[0] ? 32'h80200003 : 0). The random control word has no influence on this.
- R10: Reads of an index at or above NUM_REGS, or of an unmapped index, return 0. Writes to such indices change nothing.
- R11: Read data appears on `rdData` at the clock edge that samples `rdEn`. It holds until the next read.
- R12: The clock parameter, clock extension storage, random control and scratch words store the full 32-bit write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 12 | Byte address, word aligned |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| strapAInit | input | 32 | Reset value of the first strap |
| strapBInit | input | 32 | Reset value of the second strap |
| revisionIn | input | 32 | Reset value of the revision word |
| keyInit | input | 1 | Reset value of the key flag |

## Verification
The assertions assume the following about the inputs:
- `wrEn` and `rdEn` are never high in the same cycle.
- Address bits [1:0] are zero.
- The strap and revision inputs hold steady while reset is released.

The bench drives each access for exactly one clock, with the address aligned and only one strobe raised. It changes the strap inputs only while `rstN` is low. Under these conditions a clear write and a set write to the same pair can never land in the same cycle. This is the condition that the pair assertions depend on.

// File: rtl/keyed_regs_pkg.sv
package keyed_regs_pkg;

  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 12;
  localparam int IDX_W       = ADDR_W - 2;

  localparam int NUM_PAIRS   = 4;
  localparam int NUM_STRAPS  = 2;
  localparam int STRAP_FIRST = NUM_PAIRS - NUM_STRAPS;
  localparam int NUM_SCRATCH = 4;

  localparam int IDX_KEY     = 0;
  localparam int IDX_REV     = 1;
  localparam int IDX_ID0     = 2;
  localparam int IDX_ID1     = 3;
  localparam int PAIR_BASE   = 4;
  localparam int PAIR_STRIDE = 4;
  localparam int CLR_OFS     = 1;
  localparam int PROT_OFS    = 2;
  localparam int IDX_CLKP    = PAIR_BASE + PAIR_STRIDE * NUM_PAIRS;
  localparam int IDX_CLKX    = IDX_CLKP + 1;
  localparam int IDX_RNGC    = IDX_CLKP + 2;
  localparam int IDX_RNGD    = IDX_CLKP + 3;
  localparam int SCR_BASE    = IDX_CLKP + 4;

  localparam int LOCK_BIT    = DATA_W - 1;

  localparam logic [DATA_W-1:0] PAIR_DEFAULT [STRAP_FIRST] = '{32'hF0C30ED8, 32'h0FF07F8A};
  localparam logic [DATA_W-1:0] ID0_VALUE  = 32'h5A5A0001;
  localparam logic [DATA_W-1:0] ID1_VALUE  = 32'h0000C0DE;
  localparam logic [DATA_W-1:0] CLKP_DEF   = 32'h100040A1;
  localparam logic [DATA_W-1:0] CLKX_DEF   = 32'h00000000;
  localparam logic [DATA_W-1:0] RNGC_DEF   = 32'h0000000E;
  localparam logic [DATA_W-1:0] LFSR_MASK  = 32'h80200003;

  function automatic int setIdx(input int p);
    return PAIR_BASE + PAIR_STRIDE * p;
  endfunction

  typedef struct packed {
    logic                   keyWr;
    logic                   keyMatch;
    logic [NUM_PAIRS-1:0]   pairSet;
    logic [NUM_PAIRS-1:0]   pairClr;
    logic [NUM_STRAPS-1:0]  protWr;
    logic                   clkpWr;
    logic                   clkxWr;
    logic                   rngcWr;
    logic [NUM_SCRATCH-1:0] scrWr;
    logic                   openWr;
    logic                   rdEn;
    logic                   rdInRange;
    logic                   rngAdv;
    logic [IDX_W-1:0]       rdIdx;
  } regStrobes_t;

endpackage

// File: rtl/keyed_regs_ctrl.sv
module keyed_regs_ctrl
  import keyed_regs_pkg::*;
#(
  parameter logic [31:0] KEY_VALUE  = 32'h1688A8A8,
  parameter int          NUM_REGS   = 64,
  parameter int          PROT_LIMIT = 48
) (
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  keyOpen,
  input  logic [NUM_STRAPS-1:0] strapProtOn,
  output regStrobes_t           strb
);

  logic [IDX_W-1:0] idx;
  int               idxInt;
  logic             inRange;
  logic             guarded;
  logic             wrOk;

  assign idx     = addr[ADDR_W-1:2];
  assign idxInt  = int'(idx);
  assign inRange = idxInt < NUM_REGS;
  assign guarded = (idxInt > IDX_KEY) && (idxInt < PROT_LIMIT);
  assign wrOk    = wrEn && inRange && (!guarded || keyOpen);

  logic [NUM_PAIRS-1:0]   setHit;
  logic [NUM_PAIRS-1:0]   clrHit;
  logic [NUM_STRAPS-1:0]  protHit;
  logic [NUM_SCRATCH-1:0] scrHit;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    if (p >= STRAP_FIRST) begin : g_strap
      assign setHit[p] = wrOk && (idxInt == setIdx(p)) && !strapProtOn[p-STRAP_FIRST];
      assign protHit[p-STRAP_FIRST] = wrOk && (idxInt == setIdx(p) + PROT_OFS);
    end else begin : g_plain
      assign setHit[p] = wrOk && (idxInt == setIdx(p));
    end
    assign clrHit[p] = wrOk && (idxInt == setIdx(p) + CLR_OFS);
  end

  for (genvar s = 0; s < NUM_SCRATCH; s++) begin : g_scr
    assign scrHit[s] = wrOk && (idxInt == SCR_BASE + s);
  end

  always_comb begin
    strb           = '0;
    strb.keyWr     = wrOk && (idxInt == IDX_KEY);
    strb.keyMatch  = (wrData == KEY_VALUE);
    strb.pairSet   = setHit;
    strb.pairClr   = clrHit;
    strb.protWr    = protHit;
    strb.clkpWr    = wrOk && (idxInt == IDX_CLKP);
    strb.clkxWr    = wrOk && (idxInt == IDX_CLKX);
    strb.rngcWr    = wrOk && (idxInt == IDX_RNGC);
    strb.scrWr     = scrHit;
    strb.openWr    = wrOk && (idxInt == PROT_LIMIT);
    strb.rdEn      = rdEn;
    strb.rdInRange = inRange;
    strb.rngAdv    = rdEn && inRange && (idxInt == IDX_RNGD);
    strb.rdIdx     = idx;
  end

endmodule

// File: rtl/keyed_regs_dp.sv
module keyed_regs_dp
  import keyed_regs_pkg::*;
#(
  parameter logic [31:0] LFSR_SEED  = 32'h2468ACE1,
  parameter int          PROT_LIMIT = 48
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobes_t           strb,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [DATA_W-1:0]     strapInit [NUM_STRAPS],
  input  logic [DATA_W-1:0]     revisionIn,
  input  logic                  keyInit,
  output logic                  keyOpen,
  output logic [NUM_STRAPS-1:0] strapProtOn,
  output logic [DATA_W-1:0]     rdData
);

  logic              keyFlag;
  logic [DATA_W-1:0] revReg;
  logic [DATA_W-1:0] pairReg [NUM_PAIRS];
  logic [DATA_W-1:0] protReg [NUM_STRAPS];
  logic [DATA_W-1:0] clkpReg;
  logic [DATA_W-1:0] clkxReg;
  logic [DATA_W-1:0] rngcReg;
  logic [DATA_W-1:0] scrReg  [NUM_SCRATCH];
  logic [DATA_W-1:0] openReg;
  logic [DATA_W-1:0] lfsr;
  logic [DATA_W-1:0] rdMux;
  int                rIdx;

  function automatic logic [DATA_W-1:0] lfsrStep(input logic [DATA_W-1:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
  endfunction

  assign keyOpen = keyFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyFlag <= keyInit;
      revReg  <= revisionIn;
      clkpReg <= CLKP_DEF;
      clkxReg <= CLKX_DEF;
      rngcReg <= RNGC_DEF;
      openReg <= '0;
      lfsr    <= LFSR_SEED;
    end else begin
      if (strb.keyWr)  keyFlag <= strb.keyMatch;
      if (strb.clkpWr) clkpReg <= wrData;
      if (strb.clkxWr) clkxReg <= wrData;
      if (strb.rngcWr) rngcReg <= wrData;
      if (strb.openWr) openReg <= wrData;
      if (strb.rngAdv) lfsr    <= lfsrStep(lfsr);
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [DATA_W-1:0] resetVal;
    if (p >= STRAP_FIRST) begin : g_strapInit
      assign resetVal = strapInit[p-STRAP_FIRST];
    end else begin : g_fixedInit
      assign resetVal = PAIR_DEFAULT[p];
    end

    always_ff @(posedge clk) begin
      if (!rstN)                 pairReg[p] <= resetVal;
      else if (strb.pairSet[p])  pairReg[p] <= pairReg[p] | wrData;
      else if (strb.pairClr[p])  pairReg[p] <= pairReg[p] & ~wrData;
    end

    // R4: a set write never drops a bit that was already stored
    a_r4_set_keeps: assert property (@(posedge clk) disable iff (!rstN)
      strb.pairSet[p] |=> ((pairReg[p] & $past(pairReg[p])) == $past(pairReg[p])));
    // R5: after a clear write, none of the written ones remain
    a_r5_clr_clears: assert property (@(posedge clk) disable iff (!rstN)
      strb.pairClr[p] |=> ((pairReg[p] & $past(wrData)) == '0));
    // R3: storage is frozen while the key is closed
    a_r3_locked_pair: assert property (@(posedge clk) disable iff (!rstN)
      !keyFlag |=> $stable(pairReg[p]));

    if (p >= STRAP_FIRST) begin : g_strapChk
      // R6: protect word nonzero and no clear: the strap holds
      a_r6_prot_blocks_set: assert property (@(posedge clk) disable iff (!rstN)
        (protReg[p-STRAP_FIRST] != '0 && !strb.pairClr[p]) |=> $stable(pairReg[p]));
    end
  end

  for (genvar s = 0; s < NUM_STRAPS; s++) begin : g_prot
    always_ff @(posedge clk) begin
      if (!rstN)               protReg[s] <= '0;
      else if (strb.protWr[s]) protReg[s] <= wrData;
    end
    assign strapProtOn[s] = |protReg[s];
  end

  for (genvar s = 0; s < NUM_SCRATCH; s++) begin : g_scr
    always_ff @(posedge clk) begin
      if (!rstN)              scrReg[s] <= '0;
      else if (strb.scrWr[s]) scrReg[s] <= wrData;
    end
  end

  assign rIdx = int'(strb.rdIdx);

  always_comb begin
    rdMux = '0;
    if (rIdx == IDX_KEY)  rdMux = {{(DATA_W-1){1'b0}}, keyFlag};
    if (rIdx == IDX_REV)  rdMux = revReg;
    if (rIdx == IDX_ID0)  rdMux = ID0_VALUE;
    if (rIdx == IDX_ID1)  rdMux = ID1_VALUE;
    if (rIdx == IDX_CLKP) rdMux = clkpReg;
    if (rIdx == IDX_CLKX) rdMux = clkxReg | (DATA_W'(1) << LOCK_BIT);
    if (rIdx == IDX_RNGC) rdMux = rngcReg;
    if (rIdx == IDX_RNGD) rdMux = lfsr;
    if (rIdx == PROT_LIMIT) rdMux = openReg;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (rIdx == setIdx(p) || rIdx == setIdx(p) + CLR_OFS) rdMux = pairReg[p];
    end
    for (int s = 0; s < NUM_STRAPS; s++) begin
      if (rIdx == setIdx(s + STRAP_FIRST) + PROT_OFS) rdMux = protReg[s];
    end
    for (int s = 0; s < NUM_SCRATCH; s++) begin
      if (rIdx == SCR_BASE + s) rdMux = scrReg[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= strb.rdInRange ? rdMux : '0;
  end

  // R1/R7: the revision word is only ever loaded by reset
  a_r7_rev_stable: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(revReg));
  // R3: protected plain registers hold while the key is closed
  a_r3_locked_plain: assert property (@(posedge clk) disable iff (!rstN)
    !keyFlag |=> ($stable(clkpReg) && $stable(clkxReg) && $stable(rngcReg)));
  // R2: the key reads back as a single bit
  a_r2_key_bit: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdInRange && rIdx == IDX_KEY) |=> (rdData[DATA_W-1:1] == '0));
  // R8: the clock extension always reports lock
  a_r8_lock_bit: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdInRange && rIdx == IDX_CLKX) |=> rdData[LOCK_BIT]);
  // R9: the generator never falls into the all-zero state
  a_r9_lfsr_live: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);
  // R10: out-of-range reads return zero
  a_r10_oor_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !strb.rdInRange) |=> (rdData == '0));
  // R11: read data holds without a read
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdData));

endmodule

// File: rtl/keyed_ctrl_regs.sv
module keyed_ctrl_regs
  import keyed_regs_pkg::*;
#(
  parameter logic [31:0] KEY_VALUE  = 32'h1688A8A8,
  parameter int          NUM_REGS   = 64,
  parameter int          PROT_LIMIT = 48,
  parameter logic [31:0] LFSR_SEED  = 32'h2468ACE1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [11:0] addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [31:0] strapAInit,
  input  logic [31:0] strapBInit,
  input  logic [31:0] revisionIn,
  input  logic        keyInit
);

  regStrobes_t           strb;
  logic                  keyOpen;
  logic [NUM_STRAPS-1:0] strapProtOn;
  logic [DATA_W-1:0]     strapInit [NUM_STRAPS];

  assign strapInit[0] = strapAInit;
  assign strapInit[1] = strapBInit;

  keyed_regs_ctrl #(
    .KEY_VALUE (KEY_VALUE),
    .NUM_REGS  (NUM_REGS),
    .PROT_LIMIT(PROT_LIMIT)
  ) ctrl_i (
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .addr       (addr),
    .wrData     (wrData),
    .keyOpen    (keyOpen),
    .strapProtOn(strapProtOn),
    .strb       (strb)
  );

  keyed_regs_dp #(
    .LFSR_SEED (LFSR_SEED),
    .PROT_LIMIT(PROT_LIMIT)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .strapInit  (strapInit),
    .revisionIn (revisionIn),
    .keyInit    (keyInit),
    .keyOpen    (keyOpen),
    .strapProtOn(strapProtOn),
    .rdData     (rdData)
  );

endmodule

// File: tb/keyed_ctrl_regs_tb.sv
module keyed_ctrl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] strapAInit = 32'h000000F0;
  logic [31:0] strapBInit = 32'h12340000;
  logic [31:0] revisionIn = 32'h05030303;
  logic        keyInit = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  keyed_ctrl_regs dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .strapAInit(strapAInit),
    .strapBInit(strapBInit), .revisionIn(revisionIn), .keyInit(keyInit)
  );

  // {req[3:0], isRead, addr[11:0], data[31:0], expected[31:0]}
  localparam int NVEC = 45;
  localparam logic [80:0] VEC [NVEC] = '{
    {4'd3,  1'b0, 12'h010, 32'hFFFFFFFF, 32'h0},          // R3 locked set write
    {4'd3,  1'b1, 12'h010, 32'h0,        32'hF0C30ED8},   // R3
    {4'd2,  1'b0, 12'h000, 32'h12345678, 32'h0},          // R2 wrong key
    {4'd2,  1'b1, 12'h000, 32'h0,        32'h00000000},   // R2
    {4'd3,  1'b0, 12'h0C0, 32'hCAFEF00D, 32'h0},          // R3 open scratch
    {4'd3,  1'b1, 12'h0C0, 32'h0,        32'hCAFEF00D},   // R3
    {4'd2,  1'b0, 12'h000, 32'h1688A8A8, 32'h0},          // R2 right key
    {4'd2,  1'b1, 12'h000, 32'h0,        32'h00000001},   // R2
    {4'd4,  1'b0, 12'h010, 32'h00000F00, 32'h0},          // R4
    {4'd4,  1'b1, 12'h010, 32'h0,        32'hF0C30FD8},   // R4
    {4'd5,  1'b0, 12'h014, 32'hF0000008, 32'h0},          // R5
    {4'd5,  1'b1, 12'h010, 32'h0,        32'h00C30FD0},   // R5
    {4'd5,  1'b1, 12'h014, 32'h0,        32'h00C30FD0},   // R5 clear address reads word
    {4'd5,  1'b0, 12'h024, 32'hFFFFFFFF, 32'h0},          // R5
    {4'd5,  1'b1, 12'h020, 32'h0,        32'h00000000},   // R5
    {4'd4,  1'b0, 12'h020, 32'h00000005, 32'h0},          // R4
    {4'd4,  1'b1, 12'h020, 32'h0,        32'h00000005},   // R4
    {4'd6,  1'b0, 12'h030, 32'h00000F00, 32'h0},          // R6 unprotected strap set
    {4'd6,  1'b1, 12'h030, 32'h0,        32'h00000FF0},   // R6
    {4'd6,  1'b0, 12'h038, 32'h00000001, 32'h0},          // R6 protect on
    {4'd6,  1'b0, 12'h030, 32'hFFFF0000, 32'h0},          // R6 set ignored
    {4'd6,  1'b1, 12'h030, 32'h0,        32'h00000FF0},   // R6
    {4'd6,  1'b0, 12'h034, 32'h000000F0, 32'h0},          // R6 clear still acts
    {4'd6,  1'b1, 12'h030, 32'h0,        32'h00000F00},   // R6
    {4'd6,  1'b1, 12'h038, 32'h0,        32'h00000001},   // R6
    {4'd6,  1'b0, 12'h040, 32'h00000001, 32'h0},          // R6 other strap free
    {4'd6,  1'b1, 12'h040, 32'h0,        32'h12340001},   // R6
    {4'd7,  1'b0, 12'h004, 32'hFFFFFFFF, 32'h0},          // R7
    {4'd7,  1'b1, 12'h004, 32'h0,        32'h05030303},   // R7
    {4'd7,  1'b0, 12'h008, 32'h00000000, 32'h0},          // R7
    {4'd7,  1'b1, 12'h008, 32'h0,        32'h5A5A0001},   // R7
    {4'd8,  1'b0, 12'h054, 32'h00000123, 32'h0},          // R8
    {4'd8,  1'b1, 12'h054, 32'h0,        32'h80000123},   // R8
    {4'd12, 1'b0, 12'h050, 32'hDEADBEEF, 32'h0},          // R12
    {4'd12, 1'b1, 12'h050, 32'h0,        32'hDEADBEEF},   // R12
    {4'd12, 1'b0, 12'h06C, 32'h0BADC0DE, 32'h0},          // R12
    {4'd12, 1'b1, 12'h06C, 32'h0,        32'h0BADC0DE},   // R12
    {4'd10, 1'b0, 12'h018, 32'hFFFFFFFF, 32'h0},          // R10 unmapped
    {4'd10, 1'b1, 12'h018, 32'h0,        32'h00000000},   // R10
    {4'd10, 1'b0, 12'h100, 32'hFFFFFFFF, 32'h0},          // R10 beyond range
    {4'd10, 1'b1, 12'h100, 32'h0,        32'h00000000},   // R10
    {4'd3,  1'b0, 12'h000, 32'h00000000, 32'h0},          // R3 relock
    {4'd3,  1'b0, 12'h050, 32'h00000001, 32'h0},          // R3
    {4'd3,  1'b1, 12'h050, 32'h0,        32'hDEADBEEF},   // R3
    {4'd10, 1'b1, 12'hFFC, 32'h0,        32'h00000000}    // R10
  };

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finishRun();
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [31:0] lfsrNext(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h80200003 : 32'h0);
  endfunction

  initial begin
    logic [31:0] got;
    logic [31:0] model;
    applyReset();

    // R1 reset state
    doRead(12'h000, got); check("R1 key", got, 32'h0);
    doRead(12'h004, got); check("R1 rev", got, 32'h05030303);
    doRead(12'h030, got); check("R1 strapA", got, 32'h000000F0);
    doRead(12'h040, got); check("R1 strapB", got, 32'h12340000);
    doRead(12'h010, got); check("R1 pair0", got, 32'hF0C30ED8);
    doRead(12'h020, got); check("R1 pair1", got, 32'h0FF07F8A);
    doRead(12'h00C, got); check("R1 id1", got, 32'h0000C0DE);
    doRead(12'h050, got); check("R1 clkp", got, 32'h100040A1);
    doRead(12'h058, got); check("R1 rngc", got, 32'h0000000E);
    doRead(12'h054, got); check("R8 reset ext", got, 32'h80000000);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][76]) begin
        doRead(VEC[i][75:64], got);
        total++;
        if (got !== VEC[i][31:0]) begin
          bad++;
          $display("FAIL R%0d vec %0d: actual=%h expected=%h", VEC[i][80:77], i, got, VEC[i][31:0]);
        end
      end else begin
        doWrite(VEC[i][75:64], VEC[i][63:32]);
      end
    end

    // R9 random stream, generator disabled, R7 write to it ignored
    model = 32'h2468ACE1;
    doWrite(12'h000, 32'h1688A8A8);
    doWrite(12'h058, 32'h00000000);
    doRead(12'h058, got); check("R12 rngc", got, 32'h0);
    for (int k = 0; k < 3; k++) begin
      doRead(12'h05C, got); check("R9 random", got, model);
      model = lfsrNext(model);
    end
    doWrite(12'h05C, 32'hFFFFFFFF);
    doRead(12'h05C, got); check("R7 random ro", got, model);
    model = lfsrNext(model);

    // R11 hold and latency
    doRead(12'h008, got); check("R11 read", got, 32'h5A5A0001);
    repeat (3) @(negedge clk);
    check("R11 hold", rdData, 32'h5A5A0001);
    doRead(12'h05C, got); check("R9 after hold", got, model);

    // R1 second reset with open key and new straps
    keyInit = 1'b1;
    strapAInit = 32'hA5A50000;
    applyReset();
    doRead(12'h000, got); check("R1 key init", got, 32'h1);
    doRead(12'h030, got); check("R1 strapA new", got, 32'hA5A50000);
    doRead(12'h038, got); check("R1 prot clear", got, 32'h0);
    doRead(12'h05C, got); check("R1 seed", got, 32'h2468ACE1);
    doWrite(12'h050, 32'h00C0FFEE);
    doRead(12'h050, got); check("R3 open by init", got, 32'h00C0FFEE);

    finishRun();
  end

endmodule